// File: doc/BRIEF.md
# Multiply-Accumulate Forwarding Issue Interlock

This block decides, one instruction at a time and in program order, the cycle in which a packed-SIMD multiply or multiply-accumulate may enter a fixed-latency multiplier pipeline. Every descriptor presented at its input names an operation class, the element signedness and size, whether the operands are 64-bit or 128-bit, a destination tag and an accumulator tag. The interlock keeps a per-tag ready-time scoreboard for results still in flight, and beside it a record of the single multiply that issued in the previous cycle. A dependent accumulate is released immediately when that record can forward into its accumulator input. Otherwise it waits for the normal writeback.

A 64-bit operation takes one issue cycle. A 128-bit operation takes two back-to-back passes, low half first. Two-pass operations never forward, because their halves form two separate chains and there is only one forwarding accumulator. For the same reason a wide consumer of a wide producer can start its low half one cycle before the producer's high half has written back. Any non-multiply operation that issues in between breaks the chain. Each issued pass is reported one cycle later on a log port that carries the pass's cycle number, its half and whether it was served by forwarding.

Top module: `mac_fwd_interlock`

## Requirements
- R1: During and right after reset no pass is logged (`iss_valid` = 0, `iss_fwd` = 0) and, with no descriptor offered, `stall` is 0.
- R2: An accumulate (`in_cls` 1 = add-accumulate, 2 = subtract-accumulate) whose `in_acc` equals the `in_dst` of a 64-bit multiply-class operation (`in_cls` 0, 1 or 2) issued in the previous cycle, with equal `in_sgn` and `in_size`, issues with no stall and is logged with `iss_fwd` = 1.
- R3: When signedness or element size (`in_size` 0 = 8-bit, 1 = 16-bit, 2 = 32-bit) differ from the producer, no forwarding is used, and the accumulate waits for normal writeback.
- R4: Without forwarding, an accumulate issues no earlier than 6 cycles after the last pass of the instruction that writes its accumulator tag.
- R5: A 128-bit operation (`in_wide` = 1) issues as two passes in consecutive cycles, logged with `iss_hi` = 0 then 1. The descriptor is accepted (`in_ready` = 1) only on the second pass.
- R6: 128-bit accumulates never forward. A 128-bit accumulate that depends on a 128-bit producer starts its low pass 6 cycles after the producer's low pass, which is 4 stall cycles when it is presented right away.
- R7: Any operation with `in_cls` = 3 that issues between a producer and its consumer breaks forwarding, and the consumer then waits the full latency.
- R8: The lane-scalar operand flag `in_scalar` has no effect on issue timing or forwarding.
- R9: `stall` is 1 exactly in the cycles where a presented descriptor cannot issue, and the number of stalled cycles equals the total wait that R3, R4 and R6 impose.
- R10: Each issued pass is logged one cycle after it issues, and `iss_cycle` holds the cycle number of that pass counted from the first cycle after reset.
- R11: A plain multiply, and an accumulate whose tag has no result in flight, issue without stall and with `iss_fwd` = 0 unless R2 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered; held until accepted |
| in_ready | output | 1 | Descriptor accepted this cycle (last pass issues) |
| in_cls | input | 2 | 0 multiply, 1 add-accumulate, 2 subtract-accumulate, 3 other |
| in_sgn | input | 1 | Element signedness |
| in_size | input | 2 | Element size code |
| in_wide | input | 1 | 128-bit operands (two passes) |
| in_scalar | input | 1 | Lane-scalar operand form |
| in_dst | input | TW | Destination tag |
| in_acc | input | TW | Accumulator source tag |
| stall | output | 1 | Offered descriptor cannot issue this cycle |
| iss_valid | output | 1 | A pass issued in the previous cycle |
| iss_hi | output | 1 | Logged pass is the high half |
| iss_fwd | output | 1 | Logged pass uses the forwarding accumulator |
| iss_cycle | output | CW | Cycle number of the logged pass |
| iss_dst | output | TW | Destination tag of the logged pass |

## Verification
Two functions can claim the same cycle. The forwarding check and the scoreboard check can both approve one accumulate, as when a matching producer sits in the previous cycle while the tag's older writeback is also still pending. Separately, a scoreboard write for a new producer can land in the cycle in which the same tag's earlier entry expires. Back-to-back chains that rewrite one tag, mismatched chains that later resume forwarding, and wide-on-wide chains provoke these collisions. A reference ready-time model in the bench judges every issue cycle, every forwarding flag and the stalled-cycle total.

// File: rtl/mac_il_pkg.sv
package mac_il_pkg;
  typedef enum logic [1:0] {
    CLS_MUL = 2'd0,
    CLS_MLA = 2'd1,
    CLS_MLS = 2'd2,
    CLS_OTH = 2'd3
  } mac_cls_e;

  localparam int unsigned MAC_LAT = 6;

  function automatic logic cls_is_acc(input mac_cls_e c);
    return (c == CLS_MLA) || (c == CLS_MLS);
  endfunction

  function automatic logic cls_is_mul(input mac_cls_e c);
    return c != CLS_OTH;
  endfunction
endpackage

// File: rtl/mac_il_scoreboard.sv
module mac_il_scoreboard #(
  parameter int NTAG = 16,
  parameter int TW   = 4,
  parameter int CW   = 16,
  parameter int LAT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cyc,
  input  logic [TW-1:0] rd_tag,
  input  logic          rd_wide,
  output logic          rd_ok,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_tag,
  input  logic          wr_wide
);
  logic [CW-1:0] rdy  [NTAG];
  logic [NTAG-1:0] pend;
  logic [NTAG-1:0] wd;

  for (genvar g = 0; g < NTAG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g] <= 1'b0;
        wd[g]   <= 1'b0;
        rdy[g]  <= '0;
      end else if (wr_en && wr_tag == TW'(g)) begin
        pend[g] <= 1'b1;
        wd[g]   <= wr_wide;
        rdy[g]  <= cyc + CW'(LAT);
      end else if (pend[g] && rdy[g] == cyc) begin
        pend[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_ok = !pend[rd_tag] || (rdy[rd_tag] == cyc) ||
            (rd_wide && wd[rd_tag] && rdy[rd_tag] == cyc + CW'(1));
  end
endmodule

// File: rtl/mac_il_chain.sv
module mac_il_chain #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_take,
  input  logic          take_mul,
  input  logic          take_wide,
  input  logic          take_sgn,
  input  logic [1:0]    take_size,
  input  logic [TW-1:0] take_dst,
  input  logic          q_acc,
  input  logic          q_wide,
  input  logic          q_sgn,
  input  logic [1:0]    q_size,
  input  logic [TW-1:0] q_tag,
  output logic          fwd_ok
);
  logic          pv;
  logic          p_sgn;
  logic [1:0]    p_size;
  logic [TW-1:0] p_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv     <= 1'b0;
      p_sgn  <= 1'b0;
      p_size <= '0;
      p_dst  <= '0;
    end else begin
      pv <= acc_take && take_mul && !take_wide;
      if (acc_take) begin
        p_sgn  <= take_sgn;
        p_size <= take_size;
        p_dst  <= take_dst;
      end
    end
  end

  always_comb begin
    fwd_ok = pv && q_acc && !q_wide && (q_tag == p_dst) &&
             (q_sgn == p_sgn) && (q_size == p_size);
  end
endmodule

// File: rtl/mac_fwd_interlock.sv
module mac_fwd_interlock
  import mac_il_pkg::*;
#(
  parameter int NTAG = 16,
  parameter int TW   = $clog2(NTAG),
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_cls,
  input  logic          in_sgn,
  input  logic [1:0]    in_size,
  input  logic          in_wide,
  input  logic          in_scalar,
  input  logic [TW-1:0] in_dst,
  input  logic [TW-1:0] in_acc,
  output logic          stall,
  output logic          iss_valid,
  output logic          iss_hi,
  output logic          iss_fwd,
  output logic [CW-1:0] iss_cycle,
  output logic [TW-1:0] iss_dst
);
  mac_cls_e      cls;
  logic [CW-1:0] cyc;
  logic          pass2;
  logic          is_acc, is_mul;
  logic          sb_ok, fwd_ok, can, issue_now, fwd_used;
  logic          unused_scalar;

  assign cls           = mac_cls_e'(in_cls);
  assign is_acc        = cls_is_acc(cls);
  assign is_mul        = cls_is_mul(cls);
  assign unused_scalar = in_scalar;

  mac_il_scoreboard #(.NTAG(NTAG), .TW(TW), .CW(CW), .LAT(MAC_LAT)) u_sb (
    .clk(clk), .rst(rst), .cyc(cyc),
    .rd_tag(in_acc), .rd_wide(in_wide), .rd_ok(sb_ok),
    .wr_en(in_ready && is_mul), .wr_tag(in_dst), .wr_wide(in_wide)
  );

  mac_il_chain #(.TW(TW)) u_chain (
    .clk(clk), .rst(rst),
    .acc_take(in_ready), .take_mul(is_mul), .take_wide(in_wide),
    .take_sgn(in_sgn), .take_size(in_size), .take_dst(in_dst),
    .q_acc(is_acc), .q_wide(in_wide), .q_sgn(in_sgn), .q_size(in_size),
    .q_tag(in_acc), .fwd_ok(fwd_ok)
  );

  always_comb begin
    can       = !is_acc || fwd_ok || sb_ok;
    issue_now = in_valid && (pass2 || can);
    in_ready  = in_valid && (pass2 || (can && !in_wide));
    stall     = in_valid && !pass2 && !can;
    fwd_used  = in_valid && !pass2 && fwd_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc       <= '0;
      pass2     <= 1'b0;
      iss_valid <= 1'b0;
      iss_hi    <= 1'b0;
      iss_fwd   <= 1'b0;
      iss_cycle <= '0;
      iss_dst   <= '0;
    end else begin
      cyc       <= cyc + CW'(1);
      pass2     <= issue_now && !pass2 && in_wide;
      iss_valid <= issue_now;
      iss_hi    <= pass2;
      iss_fwd   <= fwd_used;
      iss_cycle <= cyc;
      iss_dst   <= in_dst;
    end
  end
endmodule

// File: rtl/mac_fwd_interlock_chk.sv
module mac_fwd_interlock_chk #(
  parameter int TW = 4,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          stall,
  input logic          iss_valid,
  input logic          iss_hi,
  input logic          iss_fwd,
  input logic [CW-1:0] iss_cycle,
  input logic [TW-1:0] iss_dst
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!iss_valid && !iss_fwd));

  a_r2_fwd_follows_narrow: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_fwd) |-> ($past(iss_valid) && !$past(iss_hi)));

  a_r5_hi_after_lo: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && $past(iss_valid) && !$past(iss_hi) && iss_hi) |->
      (iss_dst == $past(iss_dst)));

  a_r5_hi_has_lo: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_hi) |-> ($past(iss_valid) && !$past(iss_hi)));

  a_r9_stall_blocks_accept: assert property (@(posedge clk) disable iff (rst)
    stall |-> (in_valid && !in_ready));

  a_r10_cycle_steps: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && $past(iss_valid)) |-> (iss_cycle == $past(iss_cycle) + CW'(1)));
endmodule

bind mac_fwd_interlock mac_fwd_interlock_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .stall(stall), .iss_valid(iss_valid), .iss_hi(iss_hi), .iss_fwd(iss_fwd),
  .iss_cycle(iss_cycle), .iss_dst(iss_dst)
);

// File: tb/mac_fwd_interlock_bench.sv
`timescale 1ns/1ps
module mac_fwd_interlock_bench;
  localparam int NTAG = 16;
  localparam int TW   = 4;
  localparam int CW   = 16;
  localparam int MAXP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sgn = 1'b0, in_wide = 1'b0, in_scalar = 1'b0;
  logic [1:0] in_cls = 2'd0, in_size = 2'd0;
  logic [TW-1:0] in_dst = '0, in_acc = '0;
  logic in_ready, stall, iss_valid, iss_hi, iss_fwd;
  logic [CW-1:0] iss_cycle;
  logic [TW-1:0] iss_dst;

  always #2.5 clk = ~clk;

  mac_fwd_interlock #(.NTAG(NTAG), .TW(TW), .CW(CW)) u_mac_fwd_interlock (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_sgn(in_sgn), .in_size(in_size), .in_wide(in_wide),
    .in_scalar(in_scalar), .in_dst(in_dst), .in_acc(in_acc), .stall(stall),
    .iss_valid(iss_valid), .iss_hi(iss_hi), .iss_fwd(iss_fwd),
    .iss_cycle(iss_cycle), .iss_dst(iss_dst)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // program
  int np;
  logic [1:0] p_cls [MAXP];
  logic p_sgn [MAXP], p_wide [MAXP], p_scl [MAXP];
  logic [1:0] p_size [MAXP];
  int p_dst [MAXP], p_acc [MAXP];

  // observation
  int nlo, stall_cnt, bcyc;
  bit rec;
  int o_cyc [MAXP], o_hi [MAXP];
  logic o_fwd [MAXP];

  always @(posedge clk) if (rst) bcyc <= 0; else bcyc <= bcyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rec) begin
      if (stall) stall_cnt++;
      if (iss_valid) begin
        check("R10", "log cycle", int'(iss_cycle), bcyc - 1);
        if (!iss_hi) begin
          if (nlo < MAXP) begin o_cyc[nlo] = int'(iss_cycle); o_fwd[nlo] = iss_fwd; end
          nlo++;
        end else if (nlo > 0 && nlo <= MAXP) o_hi[nlo-1] = int'(iss_cycle);
      end
    end
  end

  task automatic put(input int i, input logic [1:0] c, input logic s, input logic [1:0] z,
                     input logic w, input logic sc, input int d, input int a);
    p_cls[i] = c; p_sgn[i] = s; p_size[i] = z; p_wide[i] = w;
    p_scl[i] = sc; p_dst[i] = d; p_acc[i] = a;
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_prog(input string req);
    int e_cyc [MAXP];
    logic e_fwd [MAXP];
    int rdy [NTAG];
    bit wd [NTAG];
    bit pv; int plast, pdst; logic psg; logic [1:0] psz;
    int t, e, wait_sum;
    for (int k = 0; k < NTAG; k++) begin rdy[k] = 0; wd[k] = 0; end
    pv = 0; plast = -10; pdst = 0; psg = 0; psz = 0; t = 0; wait_sum = 0;
    // reference ready-time model
    for (int i = 0; i < np; i++) begin
      bit acc, f;
      acc = (p_cls[i] == 2'd1) || (p_cls[i] == 2'd2);
      f = acc && pv && plast == t - 1 && p_acc[i] == pdst && p_sgn[i] == psg &&
          p_size[i] == psz && !p_wide[i];
      e = t;
      if (acc && !f) begin
        int r;
        r = rdy[p_acc[i]] - ((p_wide[i] && wd[p_acc[i]]) ? 1 : 0);
        if (r > e) e = r;
      end
      e_cyc[i] = e; e_fwd[i] = f; wait_sum += e - t;
      plast = p_wide[i] ? e + 1 : e;
      t = plast + 1;
      if (p_cls[i] != 2'd3) begin
        rdy[p_dst[i]] = plast + 6; wd[p_dst[i]] = p_wide[i];
        pv = !p_wide[i]; pdst = p_dst[i]; psg = p_sgn[i]; psz = p_size[i];
      end else pv = 0;
    end
    do_reset();
    nlo = 0; stall_cnt = 0; rec = 1;
    for (int i = 0; i < np; i++) begin
      in_valid = 1'b1; in_cls = p_cls[i]; in_sgn = p_sgn[i]; in_size = p_size[i];
      in_wide = p_wide[i]; in_scalar = p_scl[i];
      in_dst = TW'(p_dst[i]); in_acc = TW'(p_acc[i]);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rec = 0;
    check(req, "issued count", nlo, np);
    for (int i = 0; i < np && i < nlo; i++) begin
      check(req, $sformatf("issue cycle of op %0d", i), o_cyc[i] - o_cyc[0], e_cyc[i]);
      check(req, $sformatf("fwd flag of op %0d", i), int'(o_fwd[i]), int'(e_fwd[i]));
      if (p_wide[i]) check("R5", $sformatf("hi pass of op %0d", i), o_hi[i], o_cyc[i] + 1);
    end
    check("R9", {req, " stall cycles"}, stall_cnt, wait_sum);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rec = 0;
    do_reset();
    repeat (2) @(negedge clk);
    #1;
    check("R1", "iss_valid after reset", int'(iss_valid), 0);
    check("R1", "stall idle", int'(stall), 0);

    // R2 + R8: 64-bit chain of eight, scalar flag toggled
    np = 8;
    put(0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1, 0);
    for (int i = 1; i < 8; i++) put(i, (i % 3 == 0) ? 2'd2 : 2'd1, 1'b0, 2'd1, 1'b0, 1'(i % 2), 1, 1);
    run_prog("R2/R8 narrow chain");

    // R6: 128-bit chain
    np = 4;
    put(0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0, 2, 0);
    for (int i = 1; i < 4; i++) put(i, 2'd1, 1'b1, 2'd1, 1'b1, 1'b1, 2, 2);
    run_prog("R6 wide chain");

    // R3/R4: signedness then size mismatch, with forwarding in between
    np = 4;
    put(0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 3, 0);
    put(1, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 3, 3);
    put(2, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 3, 3);
    put(3, 2'd2, 1'b1, 2'd1, 1'b0, 1'b0, 3, 3);
    run_prog("R3/R4 mismatch");

    // R7: intervening other op
    np = 4;
    put(0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 4, 0);
    put(1, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 9, 9);
    put(2, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 4, 4);
    put(3, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 4, 4);
    run_prog("R7 break");

    // R11/R4: independent ops, waits on older producers, narrow after wide
    np = 6;
    put(0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 5, 0);
    put(1, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 6, 0);
    put(2, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 7, 7);
    put(3, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 5, 5);
    put(4, 2'd0, 1'b0, 2'd1, 1'b1, 1'b0, 8, 0);
    put(5, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 8, 8);
    run_prog("R11/R4 independent");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule